// File: doc/BRIEF.md
# Load-Weighted Iterative Crossbar Scheduler

This block decides, once per clock, which inputs of an input-queued packet switch may send to which outputs through the crossbar. Each input keeps one virtual output queue per output. For every queue it presents a request flag, the queue's current depth and the length of the frame at its head. The block turns these, plus a waiting-time counter it keeps for each queue, into a small priority level. It then runs several rounds of grant and accept arbitration and registers a match matrix that pairs each input with at most one output and each output with at most one input.

Heavily loaded or long-waiting queues get a higher level and so win contested outputs more often than plain round-robin matching would allow. Requests of equal level share outputs fairly through round-robin pointers. These pointers move only on matches made in the first round, which keeps the arbiters out of step with one another under steady load. Thresholds for depth, waiting time and short-frame length are configuration inputs, so firmware can set them without changing the logic.

Top module: `adaptive_voq_sched`

## Requirements
- R1: A match bit is set only if the request bit of the same input/output pair was set in the cycle before. Pair (i, j) uses bit i*N_PORTS+j of every per-pair vector.
- R2: In every cycle the match matrix holds at most one set bit per input row and at most one per output column.
- R3: The priority level of a request gains 1 when its queue depth is at least the low depth threshold, and 1 more when the depth is also at least the high depth threshold.
- R4: Each pair has a waiting counter. It counts cycles in which the request is present and not matched, saturates at its all-ones value, and clears when the pair is matched or its request drops. A count at or above the waiting threshold adds 2 to the level.
- R5: A head frame whose length is at or below the short-frame threshold adds 1 to the level.
- R6: Each output grants the highest-level request among the unmatched inputs that ask for it. Ties go to the first tied input at or after that output's grant pointer, counting upward with wraparound.
- R7: Each input accepts the highest-level grant it receives. Ties go to the first tied output at or after that input's accept pointer, with wraparound.
- R8: Only a first-round match moves pointers. The grant pointer of the output goes one past the accepted input, and the accept pointer of the input goes one past the accepted output.
- R9: Arbitration runs ITERS rounds per cycle. Inputs and outputs matched in earlier rounds take no part in later rounds, and the matches of all rounds are combined.
- R10: While reset is low, the match output, the pointers and the waiting counters are cleared, and the match reads zero in the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scheduler clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vec | input | N_PORTS*N_PORTS | Request flag per input/output pair, bit i*N_PORTS+j |
| qlen_vec | input | N_PORTS*N_PORTS*QLEN_W | Queue depth per pair |
| flen_vec | input | N_PORTS*N_PORTS*FLEN_W | Head frame length per pair |
| cfg_qlen_lo | input | QLEN_W | Low depth threshold |
| cfg_qlen_hi | input | QLEN_W | High depth threshold |
| cfg_wait_thr | input | WAIT_W | Waiting-count threshold |
| cfg_short_len | input | FLEN_W | Short-frame length threshold |
| match_vec | output | N_PORTS*N_PORTS | Registered match matrix, bit i*N_PORTS+j |

## Verification
A pointer that is stuck or moves on a later-round match changes which input wins a tied output. This shows as a different match bit within one or two scheduling cycles of repeated identical requests. A waiting counter that miscounts, wraps or fails to clear moves a level across the waiting threshold. This shows up as a contested output changing hands several cycles too early or too late. Level or round errors show on the very next match word, because each cycle's match is a pure function of that cycle's inputs and the pointer and counter state. A small four-port configuration, run through directed ties and long random sweeps against an arithmetic model, exposes each of these at the ports.

// File: rtl/sched_pkg.sv
// Package: shared types and constants of the crossbar scheduler.
// Assumes: the priority level fits in three bits (maximum value 5).
package sched_pkg;
    localparam int PRIO_W = 3;
    typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/voq_prio.sv
// Module: voq_prio
// Keeps the waiting counter of one virtual output queue and forms its
// priority level from depth, waiting count and head-frame length.
// Assumes: served_i is the combinational match decision of this cycle.
module voq_prio
    import sched_pkg::*;
#(
    parameter int QLEN_W = 8,
    parameter int FLEN_W = 12,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              served_i,
    input  logic [QLEN_W-1:0] qlen_i,
    input  logic [FLEN_W-1:0] flen_i,
    input  logic [QLEN_W-1:0] thr_qlo_i,
    input  logic [QLEN_W-1:0] thr_qhi_i,
    input  logic [WAIT_W-1:0] thr_wait_i,
    input  logic [FLEN_W-1:0] thr_short_i,
    output prio_t             prio_o,
    output logic [WAIT_W-1:0] wait_o
);
    localparam logic [WAIT_W-1:0] WAIT_MAX = '1;

    logic [WAIT_W-1:0] wait_q;
    logic              q_lo_hit, q_hi_hit, w_hit, s_hit;

    // Waiting counter: counts unserved cycles, saturates, clears on service or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
        end else if (!req_i || served_i) begin
            wait_q <= '0;
        end else if (wait_q != WAIT_MAX) begin
            wait_q <= wait_q + 1'b1;
        end
    end

    // Level: depth steps, waiting bonus of two, short-frame bonus of one.
    always_comb begin
        q_lo_hit = (qlen_i >= thr_qlo_i);
        q_hi_hit = (qlen_i >= thr_qhi_i);
        w_hit    = (wait_q >= thr_wait_i);
        s_hit    = (flen_i <= thr_short_i);
        prio_o   = {2'b00, q_lo_hit} + {2'b00, q_hi_hit}
                 + (w_hit ? 3'd2 : 3'd0) + {2'b00, s_hit};
    end

    assign wait_o = wait_q;
endmodule

// File: rtl/rr_prio_arb.sv
// Module: rr_prio_arb
// Picks one requester: highest level first, then round-robin from ptr_i.
// Assumes: ptr_i < N; output is one-hot or zero when nothing requests.
module rr_prio_arb
    import sched_pkg::*;
#(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic [N-1:0]        req_i,
    input  logic [N*PRIO_W-1:0] prio_i,
    input  logic [PW-1:0]       ptr_i,
    output logic [N-1:0]        gnt_o
);
    prio_t        best;
    logic [N-1:0] cand;
    logic         found;

    // Find the top level among active requests.
    always_comb begin
        best = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > best)) begin
                best = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end

    // Mark requests that sit at the top level.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            cand[i] = req_i[i] && (prio_i[i*PRIO_W +: PRIO_W] == best);
        end
    end

    // Scan the candidates upward from the pointer and take the first one.
    always_comb begin
        gnt_o = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = int'(ptr_i) + k;
            if (idx >= N) idx = idx - N;
            if (!found && cand[idx]) begin
                gnt_o[idx] = 1'b1;
                found      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/adaptive_voq_sched.sv
// Module: adaptive_voq_sched (top)
// Iterative grant/accept matcher with load-adaptive request levels.
// Pair (i, j) is bit i*N_PORTS+j of every per-pair vector. The match is
// computed combinationally from this cycle's inputs and registered.
// Assumes: request inputs are stable around the clock edge.
module adaptive_voq_sched
    import sched_pkg::*;
#(
    parameter int N_PORTS = 12,
    parameter int ITERS   = 3,
    parameter int QLEN_W  = 8,
    parameter int FLEN_W  = 12,
    parameter int WAIT_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_PORTS*N_PORTS-1:0]    req_vec,
    input  logic [N_PORTS*N_PORTS*QLEN_W-1:0] qlen_vec,
    input  logic [N_PORTS*N_PORTS*FLEN_W-1:0] flen_vec,
    input  logic [QLEN_W-1:0]             cfg_qlen_lo,
    input  logic [QLEN_W-1:0]             cfg_qlen_hi,
    input  logic [WAIT_W-1:0]             cfg_wait_thr,
    input  logic [FLEN_W-1:0]             cfg_short_len,
    output logic [N_PORTS*N_PORTS-1:0]    match_vec
);
    localparam int N  = N_PORTS;
    localparam int NV = N * N;
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [NV*PRIO_W-1:0] prio_flat;
    logic [NV*WAIT_W-1:0] wait_flat;
    logic [NV-1:0]        match_nxt;
    logic [PW-1:0]        gptr [N];
    logic [PW-1:0]        aptr [N];
    logic [N-1:0]         in_free  [ITERS+1];
    logic [N-1:0]         out_free [ITERS+1];
    logic [NV-1:0]        acc      [ITERS];

    // Per-queue level and waiting counter.
    for (genvar v = 0; v < NV; v++) begin : g_voq
        voq_prio #(
            .QLEN_W(QLEN_W), .FLEN_W(FLEN_W), .WAIT_W(WAIT_W)
        ) u_prio (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_i      (req_vec[v]),
            .served_i   (match_nxt[v]),
            .qlen_i     (qlen_vec[v*QLEN_W +: QLEN_W]),
            .flen_i     (flen_vec[v*FLEN_W +: FLEN_W]),
            .thr_qlo_i  (cfg_qlen_lo),
            .thr_qhi_i  (cfg_qlen_hi),
            .thr_wait_i (cfg_wait_thr),
            .thr_short_i(cfg_short_len),
            .prio_o     (prio_flat[v*PRIO_W +: PRIO_W]),
            .wait_o     (wait_flat[v*WAIT_W +: WAIT_W])
        );
    end

    assign in_free[0]  = '1;
    assign out_free[0] = '1;

    // One grant/accept round per iteration; later rounds see only free ports.
    for (genvar it = 0; it < ITERS; it++) begin : g_iter
        logic [N-1:0]        col_req  [N];
        logic [N*PRIO_W-1:0] col_prio [N];
        logic [N-1:0]        col_gnt  [N];
        logic [N-1:0]        row_req  [N];
        logic [N-1:0]        row_acc  [N];
        logic [NV-1:0]       acc_it;
        logic [N-1:0]        in_hit, out_hit;

        // Gather, per output, the live requests and their levels.
        always_comb begin
            for (int j = 0; j < N; j++) begin
                for (int i = 0; i < N; i++) begin
                    col_req[j][i] = req_vec[i*N+j] & in_free[it][i] & out_free[it][j];
                    col_prio[j][i*PRIO_W +: PRIO_W] = prio_flat[(i*N+j)*PRIO_W +: PRIO_W];
                end
            end
        end

        for (genvar j = 0; j < N; j++) begin : g_out
            rr_prio_arb #(.N(N), .PW(PW)) u_grant (
                .req_i (col_req[j]),
                .prio_i(col_prio[j]),
                .ptr_i (gptr[j]),
                .gnt_o (col_gnt[j])
            );
        end

        // Turn output grants into per-input grant rows.
        always_comb begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    row_req[i][j] = col_gnt[j][i];
                end
            end
        end

        for (genvar i = 0; i < N; i++) begin : g_in
            rr_prio_arb #(.N(N), .PW(PW)) u_accept (
                .req_i (row_req[i]),
                .prio_i(prio_flat[i*N*PRIO_W +: N*PRIO_W]),
                .ptr_i (aptr[i]),
                .gnt_o (row_acc[i])
            );
        end

        // Collect accepted pairs and the ports they occupy.
        always_comb begin
            in_hit  = '0;
            out_hit = '0;
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    acc_it[i*N+j] = row_acc[i][j];
                    in_hit[i]     = in_hit[i]  | row_acc[i][j];
                    out_hit[j]    = out_hit[j] | row_acc[i][j];
                end
            end
        end

        assign acc[it]          = acc_it;
        assign in_free[it+1]    = in_free[it]  & ~in_hit;
        assign out_free[it+1]   = out_free[it] & ~out_hit;
    end

    // Combine the matches of all rounds.
    always_comb begin
        match_nxt = '0;
        for (int it = 0; it < ITERS; it++) begin
            match_nxt = match_nxt | acc[it];
        end
    end

    // Pointers move one past the partner, on first-round matches only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) begin
                gptr[k] <= '0;
                aptr[k] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    if (acc[0][i*N+j]) begin
                        gptr[j] <= (i == N-1) ? '0 : PW'(i + 1);
                        aptr[i] <= (j == N-1) ? '0 : PW'(j + 1);
                    end
                end
            end
        end
    end

    // Registered match output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_vec <= '0;
        end else begin
            match_vec <= match_nxt;
        end
    end
endmodule

// File: rtl/sched_checks.sv
// Module: sched_checks
// Property checker bound to adaptive_voq_sched; observes ports and the
// per-queue waiting counters.
module sched_checks #(
    parameter int N      = 4,
    parameter int WAIT_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N*N-1:0]      req_vec,
    input logic [N*N-1:0]      match_vec,
    input logic [N*N*WAIT_W-1:0] wait_flat
);
    localparam logic [WAIT_W-1:0] WMAX = '1;

    logic [N-1:0] col_m [N];

    // Regroup the match matrix by output column.
    always_comb begin
        for (int c = 0; c < N; c++) begin
            for (int r = 0; r < N; r++) begin
                col_m[c][r] = match_vec[r*N+c];
            end
        end
    end

    for (genvar r = 0; r < N; r++) begin : g_row
        a_r2_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(match_vec[r*N +: N]));
        a_r2_col_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col_m[r]));
    end

    for (genvar v = 0; v < N*N; v++) begin : g_pair
        a_r1_match_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
            match_vec[v] |-> $past(req_vec[v]));
        a_r4_wait_clears_on_match: assert property (@(posedge clk) disable iff (!rst_n)
            match_vec[v] |-> (wait_flat[v*WAIT_W +: WAIT_W] == '0));
        a_r4_wait_steps_or_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (wait_flat[v*WAIT_W +: WAIT_W] != '0) |->
                ((wait_flat[v*WAIT_W +: WAIT_W] == $past(wait_flat[v*WAIT_W +: WAIT_W]) + 1'b1)
                 || ((wait_flat[v*WAIT_W +: WAIT_W] == WMAX)
                     && ($past(wait_flat[v*WAIT_W +: WAIT_W]) == WMAX))));
    end

    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (match_vec == '0));
endmodule

bind adaptive_voq_sched sched_checks #(.N(N_PORTS), .WAIT_W(WAIT_W)) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vec  (req_vec),
    .match_vec(match_vec),
    .wait_flat(wait_flat)
);

// File: tb/adaptive_voq_sched_bench.sv
`timescale 1ns/1ps
// Bench: four-port, three-round configuration. Directed tie and level cases
// with hand-computed matches, then random and full-load sweeps against an
// arithmetic model built from the requirements.
module adaptive_voq_sched_bench;
    localparam int N  = 4;
    localparam int NV = N * N;
    localparam int IT = 3;
    localparam int QW = 4;
    localparam int LW = 6;
    localparam int WW = 3;
    localparam int WMAX = 7;
    localparam int TLO = 4, THI = 10, TW = 3, TS = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NV-1:0]     req_vec = '0;
    logic [NV*QW-1:0]  qlen_vec = '0;
    logic [NV*LW-1:0]  flen_vec = '0;
    logic [NV-1:0]     match_vec;

    int checks = 0;
    int failures = 0;
    int wcnt [NV];
    int gp [N];
    int ap [N];

    always #2.5 clk = ~clk;

    adaptive_voq_sched #(
        .N_PORTS(N), .ITERS(IT), .QLEN_W(QW), .FLEN_W(LW), .WAIT_W(WW)
    ) u_adaptive_voq_sched (
        .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .qlen_vec(qlen_vec),
        .flen_vec(flen_vec), .cfg_qlen_lo(QW'(TLO)), .cfg_qlen_hi(QW'(THI)),
        .cfg_wait_thr(WW'(TW)), .cfg_short_len(LW'(TS)), .match_vec(match_vec)
    );

    task automatic chk(input string tag, input logic [NV-1:0] act, input logic [NV-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int level(input int v);
        int q, f, p;
        q = int'(qlen_vec[v*QW +: QW]);
        f = int'(flen_vec[v*LW +: LW]);
        p = 0;
        if (q >= TLO) p++;
        if (q >= THI) p++;
        if (wcnt[v] >= TW) p += 2;
        if (f <= TS) p++;
        return p;
    endfunction

    // Model of one scheduling cycle (R3..R9).
    task automatic model(output logic [NV-1:0] m, output logic [NV-1:0] a0);
        logic [N-1:0] inf, outf, inh, outh;
        logic [NV-1:0] g;
        int pr [NV];
        for (int v = 0; v < NV; v++) pr[v] = level(v);
        m = '0; a0 = '0; inf = '1; outf = '1;
        for (int it = 0; it < IT; it++) begin
            g = '0; inh = '0; outh = '0;
            for (int j = 0; j < N; j++) begin
                int best, i;
                best = -1;
                for (int k = 0; k < N; k++)
                    if (req_vec[k*N+j] && inf[k] && outf[j] && pr[k*N+j] > best) best = pr[k*N+j];
                for (int k = 0; k < N; k++) begin
                    i = (gp[j] + k) % N;
                    if (best >= 0 && req_vec[i*N+j] && inf[i] && outf[j] && pr[i*N+j] == best) begin
                        g[i*N+j] = 1'b1;
                        break;
                    end
                end
            end
            for (int i = 0; i < N; i++) begin
                int best, j;
                best = -1;
                for (int k = 0; k < N; k++)
                    if (g[i*N+k] && pr[i*N+k] > best) best = pr[i*N+k];
                for (int k = 0; k < N; k++) begin
                    j = (ap[i] + k) % N;
                    if (best >= 0 && g[i*N+j] && pr[i*N+j] == best) begin
                        m[i*N+j] = 1'b1;
                        if (it == 0) a0[i*N+j] = 1'b1;
                        inh[i] = 1'b1; outh[j] = 1'b1;
                        break;
                    end
                end
            end
            inf = inf & ~inh; outf = outf & ~outh;
        end
    endtask

    task automatic model_reset();
        for (int v = 0; v < NV; v++) wcnt[v] = 0;
        for (int k = 0; k < N; k++) begin gp[k] = 0; ap[k] = 0; end
    endtask

    // One scheduling cycle: predict, clock, compare, advance the model.
    task automatic step(input string tag, input bit use_hand, input logic [NV-1:0] hand);
        logic [NV-1:0] em, ea, rq;
        int rc, cc;
        model(em, ea);
        rq = req_vec;
        @(posedge clk);
        @(negedge clk);
        chk(tag, match_vec, em);
        if (use_hand) chk({tag, " hand"}, match_vec, hand);
        chk("R1 match within requests", match_vec & ~rq, '0);
        for (int r = 0; r < N; r++) begin
            rc = 0; cc = 0;
            for (int c = 0; c < N; c++) begin
                rc += int'(match_vec[r*N+c]);
                cc += int'(match_vec[c*N+r]);
            end
            checks++;
            if (rc > 1 || cc > 1) begin
                failures++;
                $display("FAIL R2 line %0d actual row=%0d col=%0d expected<=1", r, rc, cc);
            end
        end
        for (int v = 0; v < NV; v++) begin
            if (!rq[v] || em[v]) wcnt[v] = 0;
            else if (wcnt[v] < WMAX) wcnt[v]++;
        end
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (ea[i*N+j]) begin gp[j] = (i + 1) % N; ap[i] = (j + 1) % N; end
    endtask

    task automatic set_pair(input int i, input int j, input bit r, input int q, input int f);
        req_vec[i*N+j] = r;
        qlen_vec[(i*N+j)*QW +: QW] = QW'(q);
        flen_vec[(i*N+j)*LW +: LW] = LW'(f);
    endtask

    task automatic clear_inputs();
        req_vec = '0;
        for (int v = 0; v < NV; v++) begin
            qlen_vec[v*QW +: QW] = '0;
            flen_vec[v*LW +: LW] = LW'(20);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R10 match cleared in reset", match_vec, '0);
        clear_inputs();
        rst_n = 1'b1;
        model_reset();
    endtask

    function automatic logic [NV-1:0] bitp(input int i, input int j);
        logic [NV-1:0] b;
        b = '0;
        b[i*N+j] = 1'b1;
        return b;
    endfunction

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_inputs();
        model_reset();
        do_reset();
        step("R10 idle after reset", 1'b1, '0);

        // R3: deeper queue beats pointer order.
        do_reset();
        set_pair(0, 0, 1, 0, 20);
        set_pair(1, 0, 1, 12, 20);
        step("R3 depth level wins", 1'b1, bitp(1, 0));

        // R5: short head frame beats pointer order.
        do_reset();
        set_pair(0, 0, 1, 0, 20);
        set_pair(1, 0, 1, 0, 5);
        step("R5 short frame wins", 1'b1, bitp(1, 0));

        // R6: equal levels rotate from the grant pointer.
        do_reset();
        set_pair(0, 0, 1, 0, 20);
        set_pair(1, 0, 1, 0, 20);
        step("R6 tie first", 1'b1, bitp(0, 0));
        step("R6 tie second", 1'b1, bitp(1, 0));
        step("R6 tie wraps", 1'b1, bitp(0, 0));

        // R4: waiting count lifts a starved request past a deeper queue.
        do_reset();
        set_pair(0, 0, 1, 4, 20);
        set_pair(1, 0, 1, 0, 20);
        step("R4 wait 0", 1'b1, bitp(0, 0));
        step("R4 wait 1", 1'b1, bitp(0, 0));
        step("R4 wait 2", 1'b1, bitp(0, 0));
        step("R4 wait reaches threshold", 1'b1, bitp(1, 0));

        // R7: input accepts the higher level grant, then ties from its pointer.
        do_reset();
        set_pair(0, 0, 1, 0, 20);
        set_pair(0, 1, 1, 12, 20);
        step("R7 accept higher level", 1'b1, bitp(0, 1));
        set_pair(0, 1, 1, 0, 20);
        step("R7 accept tie from pointer", 1'b1, bitp(0, 0));

        // R9/R8: second round fills a free pair; its pointers stay put.
        do_reset();
        set_pair(0, 0, 1, 0, 20);
        set_pair(0, 1, 1, 0, 20);
        set_pair(1, 1, 1, 0, 20);
        step("R9 second round match", 1'b1, bitp(0, 0) | bitp(1, 1));
        step("R8 later round leaves pointer", 1'b1, bitp(0, 1));

        // Random sweep against the model (R3..R9).
        do_reset();
        for (int n = 0; n < 400; n++) begin
            req_vec = NV'($urandom);
            for (int v = 0; v < NV; v++) begin
                qlen_vec[v*QW +: QW] = QW'($urandom_range(0, 15));
                flen_vec[v*LW +: LW] = LW'($urandom_range(0, 40));
            end
            step("R9 random sweep", 1'b0, '0);
        end

        // Full load with equal queue levels (R6, R8).
        clear_inputs();
        req_vec = '1;
        for (int n = 0; n < 40; n++) step("R8 full load", 1'b0, '0);

        // Reset in the middle of traffic (R10).
        do_reset();
        step("R10 cleared state after mid-run reset", 1'b1, '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule